// File: doc/BRIEF.md
# Eight-Channel Two-Level Code Register Bank

This block sits behind a serial receiver in a multi-channel converter controller. Each accepted 16-bit command word carries a 4-bit operation in its top nibble and a 12-bit payload below it. The block keeps, for each of eight channels, a staging register and a live register. Only the live register drives that channel's converter code. Commands can fill the staging registers without disturbing the outputs. They can also write through both levels for one half of the bank or for the whole bank, or copy chosen staging registers into the live ones.

A level-sensitive active-low load pin makes every live register track its staging register while the pin is held low. An asynchronous active-low clear wipes both levels. Power-state commands are not handled here. They leave as a one-cycle strobe carrying payload bits 11..2. A separate level output asks the power logic to return every channel to its default powered-down state.

The command input is a valid/ready stream with no back-pressure. `cmd_ready` is always high, and a word is consumed on every rising clock edge where `cmd_valid` is high. `load_n` is sampled on the clock. `clr_n` acts at once.

Top module: `dacb_bank`

## Requirements
- R1: While `rst_n` is low, every channel code reads zero and `pwr_dflt` is high. With no command, `pwr_dflt` falls at the first clock edge after release.
- R2: Operation 0x0 changes no register.
- R3: Operation 0x1 zeroes every staging and live register. It also raises `pwr_dflt` for the next cycle.
- R4: Operations 0x2 to 0x9 load the payload into the staging register of channel 1 to channel 8 respectively, and leave the live registers unchanged.
- R5: Operation 0xA writes the payload into both levels of channels 1-4, and 0xB does the same for channels 5-8. Operation 0xC does it for all eight channels. The channels outside the chosen group are unchanged.
- R6: Operation 0xE loads the payload into all eight staging registers, and the live registers are unchanged.
- R7: Operation 0xD copies staging to live for each channel whose mask bit is 1. Payload bit 4 is the bit of channel 1 and bit 11 is the bit of channel 8. A channel whose bit is 0 keeps its live value.
- R8: At each clock edge where `load_n` is low, every live register takes the value its staging register holds after that edge. A write to a staging register therefore shows on the output in the same cycle.
- R9: Operation 0xF changes no code register. In the next cycle it raises `pwr_stb` for one cycle, with payload bits 11..2 on `pwr_bits`.
- R10: Driving `clr_n` low zeroes all channel codes at once, without waiting for a clock edge, and holds `pwr_dflt` high.
- R11: `cmd_ready` is always 1. A word presented with `cmd_valid` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_n | input | 1 | Asynchronous active-low clear of all registers |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word ready, constant 1 |
| cmd_word | input | 16 | Operation in [15:12], payload in [11:0] |
| load_n | input | 1 | Active-low level load, staging to live |
| code_out | output | 96 | Live codes, channel k (from 1) in bits [12k-1:12k-12] |
| pwr_stb | output | 1 | One-cycle strobe for a power command |
| pwr_bits | output | 10 | Payload bits 11..2 of the power command |
| pwr_dflt | output | 1 | Request to put all channels in the default power-down state |

## Verification
The assertions assume that `load_n` is synchronous to `clk`, and that `cmd_word` matters only in cycles where `cmd_valid` is high. The checks that outputs stay stable after an input-only write, a no-op or a broadcast assume that `load_n` is high in that cycle. The bench drives every input on the falling edge and keeps `load_n` high except in the level-load tests. It asserts and releases `clr_n` a quarter period after a falling edge, well away from any rising edge.

// File: rtl/dacb_pkg.sv
package dacb_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 4'h0,
    OP_ZERO   = 4'h1,
    OP_LD_LO  = 4'hA,
    OP_LD_HI  = 4'hB,
    OP_LD_ALL = 4'hC,
    OP_XFER   = 4'hD,
    OP_IN_ALL = 4'hE,
    OP_PWR    = 4'hF
  } op_e;

  // operation code of the staging write for the first channel; channel i uses FIRST_CH+i
  localparam int FIRST_CH = 2;
endpackage

// File: rtl/dacb_decode.sv
module dacb_decode
  import dacb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 12
) (
  input  logic                 valid,
  input  logic [OP_W+DW-1:0]   word,
  output logic                 clr_all,
  output logic                 pwr_hit,
  output logic [NCH-1:0]       in_we,
  output logic [NCH-1:0]       wt_we,
  output logic [NCH-1:0]       xfer,
  output logic [DW-1:0]        data
);
  localparam int HALF   = NCH / 2;
  localparam int MSK_LO = DW - NCH;

  logic [OP_W-1:0] op;

  always_comb begin
    op      = word[DW +: OP_W];
    data    = word[DW-1:0];
    clr_all = valid && (op == OP_ZERO);
    pwr_hit = valid && (op == OP_PWR);
    for (int i = 0; i < NCH; i++) begin
      wt_we[i] = valid && ((op == OP_LD_ALL) ||
                           ((op == OP_LD_LO) && (i <  HALF)) ||
                           ((op == OP_LD_HI) && (i >= HALF)));
      in_we[i] = wt_we[i] ||
                 (valid && ((op == OP_W'(FIRST_CH + i)) || (op == OP_IN_ALL)));
      xfer[i]  = valid && (op == OP_XFER) && data[MSK_LO + i];
    end
  end
endmodule

// File: rtl/dacb_chan.sv
module dacb_chan #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          clr_all,
  input  logic          in_we,
  input  logic          wt_we,
  input  logic          xfer,
  input  logic          load_n,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] code
);
  logic [DW-1:0] stage_q, stage_d;
  logic [DW-1:0] live_q, live_d;

  always_comb begin
    if (clr_all)    stage_d = '0;
    else if (in_we) stage_d = data;
    else            stage_d = stage_q;

    if (clr_all)                 live_d = '0;
    else if (wt_we)              live_d = data;
    else if (xfer || !load_n)    live_d = stage_d;
    else                         live_d = live_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= '0;
      live_q  <= '0;
    end else begin
      stage_q <= stage_d;
      live_q  <= live_d;
    end
  end

  assign code = live_q;
endmodule

// File: rtl/dacb_pwr.sv
module dacb_pwr #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          pwr_hit,
  input  logic          clr_all,
  input  logic [PW-1:0] bits_in,
  output logic          pwr_stb,
  output logic [PW-1:0] pwr_bits,
  output logic          pwr_dflt
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pwr_stb  <= 1'b0;
      pwr_bits <= '0;
      pwr_dflt <= 1'b1;
    end else begin
      pwr_stb  <= pwr_hit;
      pwr_dflt <= clr_all;
      if (pwr_hit) pwr_bits <= bits_in;
    end
  end
endmodule

// File: rtl/dacb_bank.sv
module dacb_bank
  import dacb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [OP_W+DW-1:0]   cmd_word,
  input  logic                 load_n,
  output logic [NCH*DW-1:0]    code_out,
  output logic                 pwr_stb,
  output logic [DW-3:0]        pwr_bits,
  output logic                 pwr_dflt
);
  localparam int PW = DW - 2;

  logic           arst_n;
  logic           clr_all, pwr_hit;
  logic [NCH-1:0] in_we, wt_we, xfer;
  logic [DW-1:0]  data;

  assign arst_n    = rst_n & clr_n;
  assign cmd_ready = 1'b1;

  dacb_decode #(.NCH(NCH), .DW(DW)) u_dec (
    .valid   (cmd_valid),
    .word    (cmd_word),
    .clr_all (clr_all),
    .pwr_hit (pwr_hit),
    .in_we   (in_we),
    .wt_we   (wt_we),
    .xfer    (xfer),
    .data    (data)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dacb_chan #(.DW(DW)) u_ch (
      .clk     (clk),
      .arst_n  (arst_n),
      .clr_all (clr_all),
      .in_we   (in_we[g]),
      .wt_we   (wt_we[g]),
      .xfer    (xfer[g]),
      .load_n  (load_n),
      .data    (data),
      .code    (code_out[g*DW +: DW])
    );
  end

  dacb_pwr #(.PW(PW)) u_pwr (
    .clk      (clk),
    .arst_n   (arst_n),
    .pwr_hit  (pwr_hit),
    .clr_all  (clr_all),
    .bits_in  (data[DW-1:2]),
    .pwr_stb  (pwr_stb),
    .pwr_bits (pwr_bits),
    .pwr_dflt (pwr_dflt)
  );
endmodule

// File: rtl/dacb_chk.sv
module dacb_chk #(
  parameter int NCH = 8,
  parameter int DW  = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clr_n,
  input logic                cmd_valid,
  input logic [DW+3:0]       cmd_word,
  input logic                load_n,
  input logic [NCH*DW-1:0]   code_out,
  input logic                pwr_stb,
  input logic [DW-3:0]       pwr_bits,
  input logic                pwr_dflt
);
  logic [3:0] op;
  assign op = cmd_word[DW +: 4];

  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (cmd_valid && op == 4'h0 && load_n) |=> $stable(code_out)); // R2
  AST_ZERO_ALL: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (cmd_valid && op == 4'h1) |=> (code_out == '0 && pwr_dflt)); // R3
  AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (cmd_valid && op >= 4'h2 && op <= 4'h9 && load_n) |=> $stable(code_out)); // R4
  AST_WT_ALL: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (cmd_valid && op == 4'hC) |=> (code_out == {NCH{$past(cmd_word[DW-1:0])}})); // R5
  AST_BCAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (cmd_valid && op == 4'hE && load_n) |=> $stable(code_out)); // R6
  AST_PWR_FWD: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (cmd_valid && op == 4'hF) |=> (pwr_stb && pwr_bits == $past(cmd_word[DW-1:2]))); // R9
  AST_PWR_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !(cmd_valid && op == 4'hF) |=> !pwr_stb); // R9
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (code_out == '0 && pwr_dflt)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (!cmd_valid && load_n) |=> $stable(code_out)); // R11
endmodule

bind dacb_bank dacb_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_n     (clr_n),
  .cmd_valid (cmd_valid),
  .cmd_word  (cmd_word),
  .load_n    (load_n),
  .code_out  (code_out),
  .pwr_stb   (pwr_stb),
  .pwr_bits  (pwr_bits),
  .pwr_dflt  (pwr_dflt)
);

// File: tb/dacb_bank_bench.sv
module dacb_bank_bench;
  localparam int PERIOD = 10;
  localparam int NCH = 8;
  localparam int DW  = 12;

  typedef struct packed {
    logic        ld_n;
    logic [15:0] w;
    logic [2:0]  ch;
    logic [11:0] exp;
    logic [3:0]  req;
  } vec_t;

  // each entry: apply command, then check one channel's live code
  localparam vec_t VEC [0:17] = '{
    '{1'b1, 16'h2123, 3'd0, 12'h000, 4'd4},  // R4 ch1 staging only
    '{1'b1, 16'h9ABC, 3'd7, 12'h000, 4'd4},  // R4 ch8 staging only
    '{1'b1, 16'hD010, 3'd0, 12'h123, 4'd7},  // R7 mask bit4 -> ch1
    '{1'b1, 16'h0FFF, 3'd0, 12'h123, 4'd2},  // R2 no-op
    '{1'b1, 16'hD800, 3'd7, 12'hABC, 4'd7},  // R7 mask bit11 -> ch8
    '{1'b1, 16'hA5A5, 3'd3, 12'h5A5, 4'd5},  // R5 low group
    '{1'b1, 16'h0000, 3'd4, 12'h000, 4'd5},  // R5 ch5 outside low group
    '{1'b1, 16'hB3C3, 3'd7, 12'h3C3, 4'd5},  // R5 high group
    '{1'b1, 16'h0000, 3'd0, 12'h5A5, 4'd5},  // R5 ch1 outside high group
    '{1'b1, 16'hE777, 3'd1, 12'h5A5, 4'd6},  // R6 broadcast staging
    '{1'b1, 16'hD0F0, 3'd2, 12'h777, 4'd7},  // R7 mask ch1-4
    '{1'b1, 16'h0000, 3'd4, 12'h3C3, 4'd7},  // R7 ch5 bit zero untouched
    '{1'b1, 16'hFFFF, 3'd0, 12'h777, 4'd9},  // R9 power cmd no code change
    '{1'b1, 16'hC246, 3'd5, 12'h246, 4'd5},  // R5 all channels
    '{1'b1, 16'h1000, 3'd5, 12'h000, 4'd3},  // R3 zero
    '{1'b1, 16'hDFF0, 3'd6, 12'h000, 4'd3},  // R3 staging also zeroed
    '{1'b1, 16'h6111, 3'd4, 12'h000, 4'd4},  // R4 ch5 staging
    '{1'b0, 16'h0000, 3'd4, 12'h111, 4'd8}   // R8 level load
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clr_n = 1'b1;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [15:0]       cmd_word = '0;
  logic              load_n = 1'b1;
  logic [NCH*DW-1:0] code_out;
  logic              pwr_stb;
  logic [DW-3:0]     pwr_bits;
  logic              pwr_dflt;

  int total = 0;
  int bad   = 0;

  always #(PERIOD/2) clk = ~clk;

  dacb_bank #(.NCH(NCH), .DW(DW)) u_dacb_bank (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_word(cmd_word), .load_n(load_n),
    .code_out(code_out), .pwr_stb(pwr_stb), .pwr_bits(pwr_bits),
    .pwr_dflt(pwr_dflt)
  );

  function automatic logic [11:0] chv(input int i);
    return code_out[i*DW +: DW];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic ld, input logic [15:0] w, input logic v);
    load_n = ld; cmd_word = w; cmd_valid = v;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    #(PERIOD*100000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", code_out == '0, 1);
    chk("R1", pwr_dflt, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", pwr_dflt, 0);
    chk("R11", cmd_ready, 1);

    foreach (VEC[k]) begin
      step(VEC[k].ld_n, VEC[k].w, 1'b1);
      chk($sformatf("R%0d vec%0d", VEC[k].req, k), chv(VEC[k].ch), VEC[k].exp);
    end

    // R8 staging write visible in same cycle while load low
    step(1'b0, 16'h4456, 1'b1);
    chk("R8", chv(2), 12'h456);
    step(1'b1, 16'h4999, 1'b1);
    chk("R4", chv(2), 12'h456);
    // R11 word ignored without valid
    step(1'b1, 16'hCFFF, 1'b0);
    chk("R11", chv(2), 12'h456);
    chk("R11", cmd_ready, 1);
    // R9 power strobe
    step(1'b1, 16'hFABC, 1'b1);
    chk("R9", pwr_stb, 1);
    chk("R9", pwr_bits, 10'h2AF);
    chk("R9", chv(2), 12'h456);
    step(1'b1, 16'h0000, 1'b0);
    chk("R9", pwr_stb, 0);
    // R3 default power request
    step(1'b1, 16'h1000, 1'b1);
    chk("R3", pwr_dflt, 1);
    chk("R3", code_out == '0, 1);
    step(1'b1, 16'h0000, 1'b0);
    chk("R3", pwr_dflt, 0);
    // R10 asynchronous clear
    step(1'b1, 16'hC5A5, 1'b1);
    chk("R5", chv(1), 12'h5A5);
    #(PERIOD/4);
    clr_n = 1'b0;
    #1;
    chk("R10", chv(1), 12'h000);
    chk("R10", pwr_dflt, 1);
    @(negedge clk);
    #(PERIOD/4);
    clr_n = 1'b1;
    @(negedge clk);
    chk("R10", code_out == '0, 1);
    chk("R10", pwr_dflt, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule